// File: doc/BRIEF.md
# Width-Limited In-Order Retire Controller

This block sits at the tail of an out-of-order pipeline and retires instructions, oldest first, from the head window of one thread's reorder buffer. Each cycle the buffer presents its oldest `W` entries as slots, each with status flags: valid, ready, squashed, executed, non-speculative, load, store and fault. Each slot also carries a destination-register count, a sequence number and up to `MAXD` architectural/physical register pairs. The controller scans the slots in age order and decides in the same cycle which entries leave the buffer. It raises the matching commit-map writes and, when the head needs help, sends a request back to the execute stage.

Entries that need strict ordering may act only when they are the first committed work of the cycle and no store is still waiting to write back. This covers non-speculative and barrier operations, uncached loads and faulting instructions. A faulting entry raises a trap request and freezes commit until the trap logic reports completion. The block keeps the committed thread's program counter triple and micro-PC, and a registered done sequence number. It also reports when the buffer has drained, and counts the cycles that use the full commit width.

Top module: `retire_ctrl`

## Requirements
- R1: Slots are examined from slot 0 upward and examination stops at the first slot that is not valid or not ready. At most `W` instructions commit per cycle, and `commit_cnt` gives the number committed.
- R2: A valid, ready, squashed slot is retired (`retire` bit set) but is not counted in `commit_cnt`. It writes no map entry and leaves the PC state unchanged. Scanning continues past it, and it does not count as earlier work for the first-slot rule.
- R3: A ready slot that is not executed and is non-speculative raises `nonspec_req` with its sequence number on `nonspec_seq` and `nonspec_uncached` low. It does so only if nothing committed earlier in the cycle and `stores_pending` is low. The slot is never retired and scanning stops there. Any other unexecuted slot simply stops the scan.
- R4: A ready, unexecuted load that is not marked non-speculative behaves as in R3 but drives `nonspec_uncached` high.
- R5: A ready, executed, faulting slot raises `trap_req` under the same first-slot, no-pending-store rule and is not retired. On the next cycle `trap_pending` is high. While it is high nothing retires, until a `trap_done` pulse clears it on the following edge.
- R6: Each commit applies the step pc←npc, npc←nnpc, nnpc←nnpc+4 in order, and `upc` grows by `commit_cnt`. The registers show the result after the edge.
- R7: For committed slot i and destination d, `map_we[i*MAXD+d]` is high exactly when d is below that slot's destination count. The write uses the slot's architectural and physical register fields.
- R8: `done_seq` takes the sequence number of the youngest committed slot at the edge and holds when nothing commits.
- R9: `rob_empty` is high exactly when `rob_count` equals the number of entries retired this cycle, `stores_pending` is low and no store committed this cycle.
- R10: `full_cycles` increments on every edge where `commit_cnt` equals `W` and saturates at its maximum.
- R11: After reset pc=`RESET_PC`, npc=`RESET_PC`+4, nnpc=`RESET_PC`+8, and `upc`, `done_seq`, `full_cycles` and `trap_pending` are zero.
- R12: While `thread_active` is low, no slot retires and no request or trap is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thread_active | input | 1 | Thread is selected for commit |
| trap_done | input | 1 | Trap handling finished, releases commit |
| stores_pending | input | 1 | Stores still waiting to write back |
| rob_count | input | CW | Entries currently held in the buffer |
| hd_valid | input | W | Slot holds an entry |
| hd_ready | input | W | Entry may be considered for commit |
| hd_squashed | input | W | Entry was squashed |
| hd_executed | input | W | Entry has executed |
| hd_nonspec | input | W | Non-speculative, store-conditional or barrier |
| hd_load | input | W | Entry is a load |
| hd_store | input | W | Entry is a store |
| hd_fault | input | W | Entry carries a fault |
| hd_ndest | input | W*DW | Destination count per slot |
| hd_seq | input | W*SW | Sequence number per slot |
| hd_arch | input | W*MAXD*AW | Architectural destination registers |
| hd_phys | input | W*MAXD*PW | Physical destination registers |
| retire | output | W | Slot leaves the buffer this cycle |
| commit_cnt | output | NW | Instructions committed this cycle |
| map_we | output | W*MAXD | Commit map write enables |
| map_arch | output | W*MAXD*AW | Commit map write index |
| map_phys | output | W*MAXD*PW | Commit map write data |
| nonspec_req | output | 1 | Execute request for the head entry |
| nonspec_uncached | output | 1 | Request is an uncached load |
| nonspec_seq | output | SW | Sequence number of the request |
| trap_req | output | 1 | Fault trap request |
| trap_pending | output | 1 | Commit frozen awaiting trap completion |
| done_seq | output | SW | Youngest committed sequence number |
| pc | output | 32 | Current PC |
| npc | output | 32 | Next PC |
| nnpc | output | 32 | PC after next |
| upc | output | UW | Micro-PC |
| rob_empty | output | 1 | Buffer drained with no store traffic |
| full_cycles | output | FW | Saturating full-width cycle count |

## Verification
The bench builds the block with `W`=3, `MAXD`=2 and `FW`=2. A three-slot window puts a squashed entry, a blocking entry and a normal commit into one cycle, and also lets a later slot try to use the first-slot rule. A two-bit full-width counter reaches saturation after three full cycles, so the hold at the maximum is checked. With `RESET_PC` at 0x100, the bench tracks the PC triple through mixed commit counts.

// File: rtl/retire_ctrl.sv
module retire_ctrl #(
  parameter int W        = 4,
  parameter int MAXD     = 2,
  parameter int SW       = 16,
  parameter int AW       = 5,
  parameter int PW       = 7,
  parameter int ROBD     = 32,
  parameter int UW       = 8,
  parameter int FW       = 16,
  parameter logic [31:0] RESET_PC = 32'h0,
  localparam int DW = $clog2(MAXD + 1),
  localparam int CW = $clog2(ROBD + 1),
  localparam int NW = $clog2(W + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  thread_active,
  input  logic                  trap_done,
  input  logic                  stores_pending,
  input  logic [CW-1:0]         rob_count,
  input  logic [W-1:0]          hd_valid,
  input  logic [W-1:0]          hd_ready,
  input  logic [W-1:0]          hd_squashed,
  input  logic [W-1:0]          hd_executed,
  input  logic [W-1:0]          hd_nonspec,
  input  logic [W-1:0]          hd_load,
  input  logic [W-1:0]          hd_store,
  input  logic [W-1:0]          hd_fault,
  input  logic [W*DW-1:0]       hd_ndest,
  input  logic [W*SW-1:0]       hd_seq,
  input  logic [W*MAXD*AW-1:0]  hd_arch,
  input  logic [W*MAXD*PW-1:0]  hd_phys,
  output logic [W-1:0]          retire,
  output logic [NW-1:0]         commit_cnt,
  output logic [W*MAXD-1:0]     map_we,
  output logic [W*MAXD*AW-1:0]  map_arch,
  output logic [W*MAXD*PW-1:0]  map_phys,
  output logic                  nonspec_req,
  output logic                  nonspec_uncached,
  output logic [SW-1:0]         nonspec_seq,
  output logic                  trap_req,
  output logic                  trap_pending,
  output logic [SW-1:0]         done_seq,
  output logic [31:0]           pc,
  output logic [31:0]           npc,
  output logic [31:0]           nnpc,
  output logic [UW-1:0]         upc,
  output logic                  rob_empty,
  output logic [FW-1:0]         full_cycles
);
  localparam logic [31:0]   ISZ   = 32'd4;
  localparam logic [NW-1:0] WFULL = NW'(W);

  logic [W-1:0]  commit;
  logic [NW-1:0] nret;
  logic          stop, st_commit;
  logic [31:0]   p_n, n_n, nn_n;
  logic [SW-1:0] seq_n;

  always_comb begin
    stop             = !thread_active || trap_pending;
    commit           = '0;
    retire           = '0;
    commit_cnt       = '0;
    nret             = '0;
    nonspec_req      = 1'b0;
    nonspec_uncached = 1'b0;
    nonspec_seq      = '0;
    trap_req         = 1'b0;
    st_commit        = 1'b0;
    p_n              = pc;
    n_n              = npc;
    nn_n             = nnpc;
    seq_n            = done_seq;
    for (int i = 0; i < W; i++) begin
      if (!stop) begin
        if (!hd_valid[i] || !hd_ready[i]) begin
          stop = 1'b1;
        end else if (hd_squashed[i]) begin
          retire[i] = 1'b1;
          nret      = nret + 1'b1;
        end else if (!hd_executed[i]) begin
          if ((hd_nonspec[i] || hd_load[i]) && commit_cnt == '0 && !stores_pending) begin
            nonspec_req      = 1'b1;
            nonspec_uncached = !hd_nonspec[i];
            nonspec_seq      = hd_seq[i*SW +: SW];
          end
          stop = 1'b1;
        end else if (hd_fault[i]) begin
          if (commit_cnt == '0 && !stores_pending) trap_req = 1'b1;
          stop = 1'b1;
        end else begin
          commit[i]  = 1'b1;
          retire[i]  = 1'b1;
          commit_cnt = commit_cnt + 1'b1;
          nret       = nret + 1'b1;
          st_commit  = st_commit | hd_store[i];
          seq_n      = hd_seq[i*SW +: SW];
          p_n        = n_n;
          n_n        = nn_n;
          nn_n       = nn_n + ISZ;
        end
      end
    end
  end

  for (genvar gi = 0; gi < W; gi++) begin : g_slot
    for (genvar gd = 0; gd < MAXD; gd++) begin : g_dst
      assign map_we[gi*MAXD+gd] = commit[gi] && (DW'(gd) < hd_ndest[gi*DW +: DW]);
    end
  end
  assign map_arch  = hd_arch;
  assign map_phys  = hd_phys;
  assign rob_empty = (rob_count == CW'(nret)) && !stores_pending && !st_commit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc           <= RESET_PC;
      npc          <= RESET_PC + ISZ;
      nnpc         <= RESET_PC + 2 * ISZ;
      upc          <= '0;
      done_seq     <= '0;
      trap_pending <= 1'b0;
      full_cycles  <= '0;
    end else begin
      pc       <= p_n;
      npc      <= n_n;
      nnpc     <= nn_n;
      upc      <= upc + UW'(commit_cnt);
      done_seq <= seq_n;
      if (trap_req)       trap_pending <= 1'b1;
      else if (trap_done) trap_pending <= 1'b0;
      if (commit_cnt == WFULL && full_cycles != '1) full_cycles <= full_cycles + 1'b1;
    end
  end

  assert_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
    commit_cnt <= WFULL);
  assert_nonspec_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    nonspec_req |-> (commit_cnt == '0 && !stores_pending));
  assert_trap_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> trap_pending);
  assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pending |-> (retire == '0 && !trap_req && !nonspec_req));
  assert_pc_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_cnt == NW'(1)) |=> (pc == $past(npc) && npc == $past(nnpc)));
  assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_cnt == '0) |=> $stable(done_seq));
  assert_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rob_empty |-> !stores_pending);
  assert_saturate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (full_cycles == '1) |=> (full_cycles == '1));
  assert_inactive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !thread_active |-> (retire == '0 && !trap_req && !nonspec_req));
endmodule

// File: tb/test_retire_ctrl.sv
module test_retire_ctrl;
  localparam int W = 3, MAXD = 2, SW = 16, AW = 5, PW = 7, ROBD = 32, UW = 8, FW = 2;
  localparam int DW = $clog2(MAXD + 1), CW = $clog2(ROBD + 1), NW = $clog2(W + 1);

  logic clk = 0, rst_n = 0;
  logic thread_active, trap_done, stores_pending;
  logic [CW-1:0] rob_count;
  logic [W-1:0] hd_valid, hd_ready, hd_squashed, hd_executed, hd_nonspec, hd_load, hd_store, hd_fault;
  logic [W*DW-1:0] hd_ndest;
  logic [W*SW-1:0] hd_seq;
  logic [W*MAXD*AW-1:0] hd_arch;
  logic [W*MAXD*PW-1:0] hd_phys;
  logic [W-1:0] retire;
  logic [NW-1:0] commit_cnt;
  logic [W*MAXD-1:0] map_we;
  logic [W*MAXD*AW-1:0] map_arch;
  logic [W*MAXD*PW-1:0] map_phys;
  logic nonspec_req, nonspec_uncached, trap_req, trap_pending, rob_empty;
  logic [SW-1:0] nonspec_seq, done_seq;
  logic [31:0] pc, npc, nnpc;
  logic [UW-1:0] upc;
  logic [FW-1:0] full_cycles;

  int checks = 0, errors = 0;
  logic [31:0] e_pc, e_npc, e_nnpc;
  logic [UW-1:0] e_upc;
  logic [SW-1:0] e_done;

  always #5 clk = ~clk;

  retire_ctrl #(.W(W), .MAXD(MAXD), .SW(SW), .AW(AW), .PW(PW), .ROBD(ROBD), .UW(UW), .FW(FW),
                .RESET_PC(32'h100)) i_retire_ctrl (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_slots();
    hd_valid = '0; hd_ready = '0; hd_squashed = '0; hd_executed = '0; hd_nonspec = '0;
    hd_load = '0; hd_store = '0; hd_fault = '0; hd_ndest = '0; hd_seq = '0;
    hd_arch = '0; hd_phys = '0; stores_pending = 0; trap_done = 0; thread_active = 1;
    rob_count = 5'd10;
  endtask

  task automatic slot(input int i, input logic sq, input logic ex, input logic ns, input logic ld,
                      input logic st, input logic ft, input int nd, input int sn);
    hd_valid[i] = 1; hd_ready[i] = 1; hd_squashed[i] = sq; hd_executed[i] = ex;
    hd_nonspec[i] = ns; hd_load[i] = ld; hd_store[i] = st; hd_fault[i] = ft;
    hd_ndest[i*DW +: DW] = DW'(nd); hd_seq[i*SW +: SW] = SW'(sn);
  endtask

  task automatic adv(input int k);
    for (int j = 0; j < k; j++) begin
      e_pc = e_npc; e_npc = e_nnpc; e_nnpc = e_nnpc + 4;
    end
    e_upc = e_upc + UW'(k);
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check_pc(input string req);
    check(req, pc, e_pc); check(req, npc, e_npc); check(req, nnpc, e_nnpc); check(req, upc, e_upc);
  endtask

  task automatic t_reset();
    check("R11 pc", pc, 32'h100); check("R11 npc", npc, 32'h104); check("R11 nnpc", nnpc, 32'h108);
    check("R11 upc", upc, 0); check("R11 done", done_seq, 0); check("R11 full", full_cycles, 0);
    check("R11 trap", trap_pending, 0);
  endtask

  task automatic t_basic();
    @(negedge clk); clear_slots();
    slot(0, 0, 1, 0, 0, 0, 0, 0, 11); slot(1, 0, 1, 0, 0, 0, 0, 0, 12); slot(2, 0, 1, 0, 0, 0, 0, 0, 13);
    hd_ready[2] = 0; #1;
    check("R1 retire", retire, 3'b011); check("R1 cnt", commit_cnt, 2);
    step(); adv(2); e_done = 12;
    check_pc("R6 two commits"); check("R8 done", done_seq, e_done);
  endtask

  task automatic t_full();
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); clear_slots();
      slot(0, 0, 1, 0, 0, 0, 0, 0, 20 + 3*c); slot(1, 0, 1, 0, 0, 0, 0, 0, 21 + 3*c);
      slot(2, 0, 1, 0, 0, 0, 0, 0, 22 + 3*c); #1;
      check("R1 full cnt", commit_cnt, 3);
      step(); adv(3); e_done = SW'(22 + 3*c);
      check("R10 count", full_cycles, (c < 3) ? c + 1 : 3);
    end
    check_pc("R6 full"); check("R8 done full", done_seq, e_done);
  endtask

  task automatic t_squash_nonspec();
    @(negedge clk); clear_slots();
    slot(0, 1, 0, 0, 0, 0, 0, 2, 40); slot(1, 0, 0, 1, 0, 0, 0, 0, 41); slot(2, 0, 1, 0, 0, 0, 0, 0, 42); #1;
    check("R2 retire", retire, 3'b001); check("R2 cnt", commit_cnt, 0); check("R2 map", map_we, 0);
    check("R3 req", nonspec_req, 1); check("R3 seq", nonspec_seq, 41); check("R3 unc", nonspec_uncached, 0);
    step(); check_pc("R2 pc held"); check("R8 held", done_seq, e_done);
  endtask

  task automatic t_nonspec_blocked();
    @(negedge clk); clear_slots();
    slot(0, 0, 1, 0, 0, 0, 0, 0, 50); slot(1, 0, 0, 1, 0, 0, 0, 0, 51); #1;
    check("R3 late retire", retire, 3'b001); check("R3 late req", nonspec_req, 0);
    step(); adv(1); e_done = 50;
    @(negedge clk); clear_slots(); stores_pending = 1;
    slot(0, 0, 0, 1, 0, 0, 0, 0, 52); #1;
    check("R3 pend req", nonspec_req, 0); check("R3 pend retire", retire, 0);
    step();
  endtask

  task automatic t_load();
    @(negedge clk); clear_slots();
    slot(0, 0, 0, 0, 1, 0, 0, 0, 60); slot(1, 0, 1, 0, 0, 0, 0, 0, 61); #1;
    check("R4 req", nonspec_req, 1); check("R4 unc", nonspec_uncached, 1);
    check("R4 seq", nonspec_seq, 60); check("R4 retire", retire, 0);
    step();
  endtask

  task automatic t_map();
    @(negedge clk); clear_slots();
    slot(0, 0, 1, 0, 0, 0, 0, 2, 70); slot(1, 0, 1, 0, 0, 0, 0, 0, 71); slot(2, 0, 1, 0, 0, 0, 0, 1, 72);
    hd_arch[0 +: AW] = 5'd9; hd_phys[0 +: PW] = 7'd77; #1;
    check("R7 we", map_we, 6'b010011); check("R7 arch", map_arch[0 +: AW], 9);
    check("R7 phys", map_phys[0 +: PW], 77);
    step(); adv(3); e_done = 72;
    check("R10 sat", full_cycles, 3);
  endtask

  task automatic t_empty();
    @(negedge clk); clear_slots(); rob_count = 2;
    slot(0, 0, 1, 0, 0, 0, 0, 0, 80); slot(1, 0, 1, 0, 0, 0, 0, 0, 81); #1;
    check("R9 drain", rob_empty, 1);
    hd_store[1] = 1; #1; check("R9 store", rob_empty, 0);
    hd_store[1] = 0; rob_count = 3; #1; check("R9 left", rob_empty, 0);
    clear_slots(); rob_count = 0; stores_pending = 1; #1; check("R9 pend", rob_empty, 0);
    stores_pending = 0; #1; check("R9 idle", rob_empty, 1);
    step();
  endtask

  task automatic t_fault();
    @(negedge clk); clear_slots();
    slot(0, 0, 1, 0, 0, 0, 0, 0, 90); slot(1, 0, 1, 0, 0, 0, 1, 0, 91); #1;
    check("R5 late", trap_req, 0); check("R5 late retire", retire, 3'b001);
    step(); adv(1); e_done = 90;
    @(negedge clk); clear_slots(); slot(0, 0, 1, 0, 0, 0, 1, 0, 91); #1;
    check("R5 trap", trap_req, 1); check("R5 no retire", retire, 0);
    step(); check("R5 pending", trap_pending, 1);
    @(negedge clk); clear_slots(); slot(0, 0, 1, 0, 0, 0, 0, 0, 92); #1;
    check("R5 frozen", retire, 0);
    step();
    @(negedge clk); trap_done = 1; step(); trap_done = 0;
    check("R5 released", trap_pending, 0); #1;
    check("R5 resume", retire, 3'b001);
    step(); adv(1); e_done = 92; check_pc("R5 pc");
  endtask

  task automatic t_inactive();
    @(negedge clk); clear_slots(); thread_active = 0;
    slot(0, 0, 0, 1, 0, 0, 0, 0, 99); slot(1, 0, 1, 0, 0, 0, 0, 0, 100); #1;
    check("R12 retire", retire, 0); check("R12 req", nonspec_req, 0);
    step(); check_pc("R12 pc");
  endtask

  initial begin
    clear_slots();
    e_pc = 32'h100; e_npc = 32'h104; e_nnpc = 32'h108; e_upc = 0; e_done = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    t_reset(); t_basic(); t_full(); t_squash_nonspec(); t_nonspec_blocked();
    t_load(); t_map(); t_empty(); t_fault(); t_inactive();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule